// File: doc/BRIEF.md
# Iterative CORDIC Rotator and Vector Angle Finder

This block performs the CORDIC shift-and-add algorithm one micro-rotation per clock cycle. It has a single datapath with feedback registers, so every micro-rotation goes through the same hardware. A one-cycle start pulse captures a starting vector (x, y) and an angle z, together with a mode bit. The engine then runs a fixed number of micro-rotations, three by default. In each micro-rotation, i is the iteration number. Both coordinates are shifted right by i, with sign extension. They are then added or subtracted crosswise. The angle register moves by an arctangent constant taken from a small internal table indexed by i.

The mode bit selects one of two behaviours:
- In rotate mode, the engine turns the vector by the loaded angle, and z is driven toward zero.
- In vector mode, y is driven toward zero, and z collects the angle of the original vector measured from the positive x-axis.

The processing gain of the micro-rotations is left in the result. A one-cycle done pulse marks the cycle in which the outputs are final. The outputs then keep their values until the next start pulse. A start pulse that arrives while the engine is running abandons the current job and begins a new one.

Top module: `cordic_iter`

## Requirements
- R1: While rst is high and in the first cycle after it, x_o, y_o and z_o read zero and done_o is low.
- R2: A start_i sampled high at a rising edge loads x_i, y_i, z_i and mode_i and restarts the iteration count at zero. This holds even when a job is running, including in the cycle of its last micro-rotation, and the abandoned job produces no done pulse.
- R3: Each clock edge after a load performs exactly one micro-rotation i = 0, 1, ... with direction d = +1 or -1: x' = x - d*(y >>> i), y' = y + d*(x >>> i), z' = z - d*A(i). The shifts are arithmetic and the results wrap at the register widths.
- R4: In rotate mode (mode_i = 0), d = +1 when z is zero or positive and d = -1 when z is negative.
- R5: In vector mode (mode_i = 1), d = +1 when y is negative and d = -1 otherwise. For a vector with x > 0, z ends within atan(2^-(N-1)) of the vector's angle.
- R6: Angles use a binary scale where a full turn is 2^AW. Table entry A(i) equals atan(2^-i)*2^AW/(2*pi), rounded to the nearest integer.
- R7: done_o is high for exactly one cycle, after the N-th rising edge following the edge that sampled start_i, with N = ITER = 3 by default.
- R8: When no job is running and start_i is low, x_o, y_o and z_o hold their values, whatever x_i, y_i, z_i and mode_i do.
- R9: The result is not gain-corrected. For N = 3, vector mode leaves x_o at about 1.6298 times the input magnitude, within 2.5 percent.
- R10: Changing mode_i after the load has no effect on a running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load pulse; begins a new job |
| mode_i | input | 1 | 0 rotate, 1 vector; sampled with start_i |
| x_i | input | DW | Starting x, two's complement |
| y_i | input | DW | Starting y, two's complement |
| z_i | input | AW | Starting angle, full turn = 2^AW |
| x_o | output | DW | Current or final x |
| y_o | output | DW | Current or final y |
| z_o | output | AW | Current or final angle |
| done_o | output | 1 | One-cycle pulse when outputs are final |

## Verification
Two events can fall in the same clock edge: a fresh load, and the final micro-rotation that would raise done. The bench provokes this by pulsing start_i so that it is sampled on the same edge as the third iteration of a running job. It also restarts a job in the middle of its run. In both cases the bench requires that done stays low in the slot the abandoned job would have used. It also requires that the outputs then follow the new operands, counted from the new load, in a reference model that is compared on every clock.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  typedef enum logic {
    CM_ROTATE = 1'b0,
    CM_VECTOR = 1'b1
  } cmode_e;

  localparam real TWO_PI = 6.283185307179586;

  // Arctangent of 2^-idx in a binary angle scale of 2^aw per full turn.
  function automatic int atan_step(input int idx, input int aw);
    real r;
    r = $atan(2.0 ** (-idx)) * (2.0 ** aw) / TWO_PI;
    return $rtoi(r + 0.5);
  endfunction

endpackage

// File: rtl/cordic_addsub.sv
module cordic_addsub #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic                sub,
  output logic signed [W-1:0] s
);
  always_comb begin
    if (sub) s = a - b;
    else     s = a + b;
  end
endmodule

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom #(
  parameter int AW   = 16,
  parameter int ITER = 3,
  parameter int CW   = $clog2(ITER + 1)
) (
  input  logic [CW-1:0]        idx,
  output logic signed [AW-1:0] angle
);
  import cordic_pkg::*;

  localparam int DEPTH = 2 ** CW;

  logic signed [AW-1:0] tbl [DEPTH];

  // Entries past the last iteration are zero so any index is safe.
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (g < ITER) begin : g_used
      localparam int VAL = atan_step(g, AW);
      assign tbl[g] = AW'(VAL);
    end else begin : g_pad
      assign tbl[g] = '0;
    end
  end

  assign angle = tbl[idx];
endmodule

// File: rtl/cordic_micro.sv
module cordic_micro #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 2
) (
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] y,
  input  logic signed [AW-1:0] z,
  input  logic [CW-1:0]        sh,
  input  logic signed [AW-1:0] ang,
  input  logic                 dpos,
  output logic signed [DW-1:0] nx,
  output logic signed [DW-1:0] ny,
  output logic signed [AW-1:0] nz
);
  logic signed [DW-1:0] xs, ys;

  assign xs = x >>> sh;
  assign ys = y >>> sh;

  // d = +1: x minus shifted y, y plus shifted x, z minus angle step
  cordic_addsub #(.W(DW)) u_x (.a(x), .b(ys),  .sub(dpos),  .s(nx));
  cordic_addsub #(.W(DW)) u_y (.a(y), .b(xs),  .sub(!dpos), .s(ny));
  cordic_addsub #(.W(AW)) u_z (.a(z), .b(ang), .sub(dpos),  .s(nz));
endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
  parameter int ITER = 3,
  parameter int CW   = $clog2(ITER + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [CW-1:0] cnt,
  output logic          run,
  output logic          done
);
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      run  <= 1'b1;
      done <= 1'b0;
    end else if (run) begin
      cnt  <= cnt + 1'b1;
      run  <= (cnt != LAST);
      done <= (cnt == LAST);
    end else begin
      done <= 1'b0;
    end
  end

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt == '0) && run && !done);

  assert_one_step_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !start) |=> (cnt == $past(cnt) + 1'b1));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_count_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt == CW'(ITER)) && !run);
endmodule

// File: rtl/cordic_iter.sv
module cordic_iter #(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int ITER = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 mode_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [AW-1:0] z_i,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [AW-1:0] z_o,
  output logic                 done_o
);
  import cordic_pkg::*;

  localparam int CW = $clog2(ITER + 1);

  logic signed [DW-1:0] x_q, y_q, x_n, y_n;
  logic signed [AW-1:0] z_q, z_n, ang;
  cmode_e               mode_q;
  logic [CW-1:0]        cnt;
  logic                 run, done, dpos;

  cordic_ctrl #(.ITER(ITER), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start_i),
    .cnt(cnt), .run(run), .done(done)
  );

  cordic_atan_rom #(.AW(AW), .ITER(ITER), .CW(CW)) u_rom (
    .idx(cnt), .angle(ang)
  );

  // Direction choice: drive z to zero, or drive y to zero.
  always_comb begin
    if (mode_q == CM_VECTOR) dpos = y_q[DW-1];
    else                     dpos = !z_q[AW-1];
  end

  cordic_micro #(.DW(DW), .AW(AW), .CW(CW)) u_step (
    .x(x_q), .y(y_q), .z(z_q), .sh(cnt), .ang(ang), .dpos(dpos),
    .nx(x_n), .ny(y_n), .nz(z_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      mode_q <= CM_ROTATE;
    end else if (start_i) begin
      x_q    <= x_i;
      y_q    <= y_i;
      z_q    <= z_i;
      mode_q <= cmode_e'(mode_i);
    end else if (run) begin
      x_q <= x_n;
      y_q <= y_n;
      z_q <= z_n;
    end
  end

  assign x_o    = x_q;
  assign y_o    = y_q;
  assign z_o    = z_q;
  assign done_o = done;

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (x_q == $past(x_i)) && (y_q == $past(y_i)) && (z_q == $past(z_i)));

  assert_rot_dir_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !start_i && mode_q == CM_ROTATE && !z_q[AW-1])
      |=> ($signed(z_q) <= $signed($past(z_q))));

  assert_vec_dir_R5: assert property (@(posedge clk) disable iff (rst)
    (run && !start_i && mode_q == CM_VECTOR && y_q[DW-1] && !x_q[DW-1])
      |=> ($signed(y_q) >= $signed($past(y_q))));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!run && !start_i) |=> ($stable(x_q) && $stable(y_q) && $stable(z_q)));

  assert_mode_kept_R10: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(mode_q));
endmodule

// File: tb/tb_cordic_iter.sv
module tb_cordic_iter;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int ITER = 3;
  localparam real PI2 = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic signed [DW-1:0] x_i = '0, y_i = '0;
  logic signed [AW-1:0] z_i = '0;
  logic signed [DW-1:0] x_o, y_o;
  logic signed [AW-1:0] z_o;
  logic done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  cordic_iter #(.DW(DW), .AW(AW), .ITER(ITER)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .x_i(x_i), .y_i(y_i), .z_i(z_i),
    .x_o(x_o), .y_o(y_o), .z_o(z_o), .done_o(done_o)
  );

  always #4 clk = ~clk;

  function automatic int wrapw(input int v, input int w);
    logic [31:0] t;
    t = v << (32 - w);
    return $signed(t) >>> (32 - w);
  endfunction

  function automatic int angle_of(input real rad);
    return $rtoi(rad * (2.0 ** AW) / PI2 + (rad >= 0.0 ? 0.5 : -0.5));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: registered state updated on the clock edge
  int mx = 0, my = 0, mz = 0, mcnt = 0, mrun = 0, mdone = 0, mmode = 0;
  always @(posedge clk) begin
    int d, ax, ay, tab;
    if (rst) begin
      mx <= 0; my <= 0; mz <= 0; mcnt <= 0; mrun <= 0; mdone <= 0; mmode <= 0;
    end else if (start_i) begin
      mx <= x_i; my <= y_i; mz <= z_i; mmode <= mode_i;
      mcnt <= 0; mrun <= 1; mdone <= 0;
    end else if (mrun != 0) begin
      if (mmode == 1) d = (my < 0) ? 1 : -1;
      else            d = (mz >= 0) ? 1 : -1;
      ax = mx >>> mcnt;
      ay = my >>> mcnt;
      tab = angle_of($atan(2.0 ** (-mcnt)));
      mx <= wrapw(mx - d * ay, DW);
      my <= wrapw(my + d * ax, DW);
      mz <= wrapw(mz - d * tab, AW);
      mcnt <= mcnt + 1;
      mrun <= (mcnt + 1 < ITER) ? 1 : 0;
      mdone <= (mcnt + 1 == ITER) ? 1 : 0;
    end else begin
      mdone <= 0;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(int'(done_o) == mdone, "R7 done per cycle", done_o, mdone);
      check(int'(x_o) == mx, "R3 R4 R5 R10 x per cycle", x_o, mx);
      check(int'(y_o) == my, "R3 R4 R5 R10 y per cycle", y_o, my);
      check(int'(z_o) == mz, "R3 R6 z per cycle", z_o, mz);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic load(input bit m, input int x, input int y, input int z);
    mode_i  = m;
    x_i     = DW'(x);
    y_i     = DW'(y);
    z_i     = AW'(z);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Full job with exact done timing check (R7)
  task automatic run_op(input bit m, input int x, input int y, input int z);
    load(m, x, y, z);
    check(done_o == 1'b0, "R7 no done at load", done_o, 0);
    for (int i = 1; i <= ITER; i++) begin
      @(negedge clk);
      check(done_o == (i == ITER), "R7 done slot", done_o, (i == ITER));
    end
  endtask

  initial begin
    int seed;
    int hx, hy, hz;
    real mag;
    repeat (3) @(negedge clk);
    check(x_o == 0 && y_o == 0 && z_o == 0, "R1 outputs in reset", x_o, 0);
    check(done_o == 1'b0, "R1 done in reset", done_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(x_o == 0 && z_o == 0 && done_o == 0, "R1 after reset", x_o, 0);

    // Rotation by +30 and -50 degrees
    run_op(1'b0, 10000, 0, angle_of(PI2 / 12.0));
    run_op(1'b0, 6000, -9000, angle_of(-PI2 * 50.0 / 360.0));

    // Vectoring: angle and uncompensated gain
    run_op(1'b1, 8000, 6000, 0);
    hx = angle_of($atan2(6000.0, 8000.0));
    check((z_o - hx) <= angle_of(0.125) && (hx - z_o) <= angle_of(0.125),
          "R5 vector angle", z_o, hx);
    mag = 10000.0 * 1.6298;
    check(x_o > $rtoi(mag * 0.975) && x_o < $rtoi(mag * 1.025), "R9 gain", x_o, $rtoi(mag));
    run_op(1'b1, 9000, -4000, 1000);

    // Hold after done while inputs and mode change (R8)
    hx = x_o; hy = y_o; hz = z_o;
    for (int k = 0; k < 5; k++) begin
      mode_i = ~mode_i;
      x_i = DW'(k * 1111);
      y_i = DW'(-k * 777);
      z_i = AW'(k * 999);
      @(negedge clk);
    end
    check(x_o == hx && y_o == hy && z_o == hz, "R8 hold", x_o, hx);

    // Mode flipped during a running job (R10)
    load(1'b0, 7000, 3000, angle_of(0.3));
    mode_i = 1'b1;
    repeat (ITER) @(negedge clk);
    check(done_o == 1'b1, "R10 job completes in latched mode", done_o, 1);

    // Restart mid-run (R2)
    load(1'b1, 5000, 5000, 0);
    @(negedge clk);
    load(1'b0, -8000, 2000, angle_of(0.5));
    check(x_o == -8000, "R2 restart loads", x_o, -8000);
    repeat (ITER) @(negedge clk);
    check(done_o == 1'b1, "R2 restarted job done", done_o, 1);

    // Restart on the same edge as the final iteration (R2)
    load(1'b0, 4000, 4000, angle_of(-0.4));
    repeat (ITER - 1) @(negedge clk);
    load(1'b1, 3000, -7000, 0);
    check(done_o == 1'b0, "R2 abandoned job gives no done", done_o, 0);
    check(y_o == -7000, "R2 new job loaded", y_o, -7000);
    repeat (ITER - 1) @(negedge clk);
    check(done_o == 1'b0, "R2 early done absent", done_o, 0);
    @(negedge clk);
    check(done_o == 1'b1, "R2 new job done", done_o, 1);

    // Start in the done cycle (back to back), then a sweep of patterns
    run_op(1'b1, -6000, 9000, 0);
    seed = 12345;
    for (int n = 0; n < 24; n++) begin
      seed = seed * 1103515245 + 12345;
      hx = ((seed >>> 8) % 12000);
      seed = seed * 1103515245 + 12345;
      hy = ((seed >>> 8) % 12000);
      seed = seed * 1103515245 + 12345;
      hz = (seed >>> 8) % 32768;
      run_op(n[0], hx, hy, hz);
      repeat (n % 3) @(negedge clk);
    end

    rst = 1'b1;
    @(negedge clk);
    check(x_o == 0 && done_o == 0, "R1 reset mid-life", x_o, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule